// File: doc/BRIEF.md
# Interruption State Capture Unit

This unit performs the control-state update that happens in the single cycle a processor takes an interruption. The surrounding pipeline presents the current status word, the two default-control bits (endian and privileged monitoring), the vector base, the instruction addresses that matter for the event (faulting instruction, next sequential bundle, branch target, last completed instruction), the fault address, and a description of the event: its kind (fault, trap or branch trap), its vector code, the slot it came from, whether that slot is the long-immediate slot of a long-format bundle, whether the code was running in the alternate instruction set, and whether the event is a nested data-translation fault. A one-cycle `take_i` pulse commits everything at once.

On the committing edge the unit writes the saved-status, saved-IP, last-IP and parameter registers (only when the collection-enable bit of the current status word is 1), clears the function-state register, rebuilds the syndrome register (unless the event is a nested data-translation fault), builds the handler status word and clears the register-stack frame-load flag. It also latches the handler address, which is the aligned vector base plus a fixed-stride offset chosen by the vector code. A small sequencer then spends one settle cycle before it raises `fetch_go_o` for exactly one cycle, marking serialization as complete so that the front end may fetch from `fetch_ip_o`.

The sequencer has three states. `SQ_IDLE` waits; the transition IDLE→SETTLE fires when `take_i` is 1 and is the commit edge. SETTLE→RELEASE fires unconditionally on the next edge. In `SQ_RELEASE` the fetch permission is raised, and RELEASE→IDLE follows unconditionally. `busy_o` is 1 in SETTLE and RELEASE.

Top module: `intr_capture_unit`

## Requirements
- R1: After reset `busy_o` and `fetch_go_o` are 0; the status, saved-status, saved-IP, last-IP, parameter, syndrome and fetch-address outputs are 0; `fstate_o` is 1 (only its bit 0, the valid bit, set) and `cfle_o` is 1.
- R2: With collection enable (status bit 3) at 1, a commit loads `saved_status_o` with `cur_status_i`, `param_addr_o` with `fault_addr_i`, and `saved_ip_o` with `cur_ip_i` for a fault (`kind_i`=0), `next_ip_i` for a trap (`kind_i`=1) and `branch_tgt_i` for a branch trap (`kind_i`=2).
- R3: With collection enable at 1, `last_ip_o` takes `last_ok_ip_i`, or `cur_ip_i` when `alt_isa_i` is 1.
- R4: With collection enable at 0, saved-status, saved-IP, last-IP and parameter outputs keep their previous values while the status word and fetch address are still updated.
- R5: Every commit sets `fstate_o` to all zeros (valid bit cleared).
- R6: The syndrome layout is: slot field bits 1:0, no-collection bit 2, kind bits 4:3, vector code bits 11:8, all other bits 0. It is rewritten on every commit except when `nested_dtlb_i` is 1, which leaves it unchanged.
- R7: The syndrome slot field is 0 in alternate-ISA mode; otherwise with `long_slot_i`=1 it is 2 for traps and branch traps and 1 for faults; otherwise it equals `slot_i`.
- R8: The no-collection bit is 1 when collection enable was 0 at commit, else 0, and always 0 in alternate-ISA mode.
- R9: The new status word keeps bits 0 (user monitor), 1 and 2 (FP-modified low/high), 5 (key enable), 8 (data translation), 9 (stack translation), 10 (machine-check mask) and 11 (instruction translation) from `cur_status_i`; bit 6 takes `def_endian_i`, bit 7 takes `def_pmon_i`; every other bit, including the privilege field 13:12, becomes 0.
- R10: Every commit clears `cfle_o`.
- R11: `fetch_ip_o` becomes `vec_base_i` with bits 14:0 forced to 0 plus `code_i`×0x400; `busy_o` rises after the commit edge, `fetch_go_o` is 1 only in the second cycle after it and `busy_o` falls one cycle later.
- R12: `take_i` while `busy_o` is 1 is ignored: no output register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Commit an interruption this cycle |
| kind_i | input | 2 | 0 fault, 1 trap, 2 branch trap |
| code_i | input | CODE_W | Vector code |
| slot_i | input | 2 | Slot of the interrupting instruction |
| long_slot_i | input | 1 | Event on long-immediate slot of a long-format bundle |
| alt_isa_i | input | 1 | Event raised in alternate instruction set |
| nested_dtlb_i | input | 1 | Event is a nested data-translation fault |
| cur_status_i | input | 32 | Current status word |
| def_endian_i | input | 1 | Default endian bit |
| def_pmon_i | input | 1 | Default privileged-monitor bit |
| vec_base_i | input | ADDR_W | Vector table base |
| cur_ip_i | input | ADDR_W | Address of the interrupting instruction |
| next_ip_i | input | ADDR_W | Next sequential bundle address |
| branch_tgt_i | input | ADDR_W | Branch target |
| last_ok_ip_i | input | ADDR_W | Last successfully completed instruction |
| fault_addr_i | input | ADDR_W | Fault parameter address |
| busy_o | output | 1 | Sequence in progress |
| fetch_go_o | output | 1 | Serialization complete, fetch may start |
| fetch_ip_o | output | ADDR_W | Handler fetch address |
| status_o | output | 32 | New status word |
| saved_status_o | output | 32 | Saved status word |
| saved_ip_o | output | ADDR_W | Saved resume address |
| last_ip_o | output | ADDR_W | Last-IP register |
| param_addr_o | output | ADDR_W | Fault parameter register |
| fstate_o | output | FS_W | Function-state register |
| syndrome_o | output | 16 | Syndrome register |
| cfle_o | output | 1 | Register-stack frame-load enable |

## Verification
The bench builds the unit with its defaults: 64-bit addresses, a 4-bit vector code with a 0x400 stride and an 8-bit function-state register. With 16 vectors the largest offset, 0x3C00, stays below the 15 cleared base bits, so a base with all low bits set shows the masking and the offset together. The full address width lets the bench drive distinct upper-half patterns into every address source, so a wrong source selection between faults, traps and branch traps cannot go unnoticed.

// File: rtl/intr_capture_pkg.sv
package intr_capture_pkg;

    localparam int STAT_W = 32;
    localparam int SYN_W  = 16;

    // status word bit positions
    localparam int SB_USER_MON  = 0;
    localparam int SB_FP_LO_MOD = 1;
    localparam int SB_FP_HI_MOD = 2;
    localparam int SB_COLLECT   = 3;
    localparam int SB_INTR_EN   = 4;
    localparam int SB_KEY_EN    = 5;
    localparam int SB_ENDIAN    = 6;
    localparam int SB_PRIV_MON  = 7;
    localparam int SB_DATA_XL   = 8;
    localparam int SB_STACK_XL  = 9;
    localparam int SB_MCHK_MASK = 10;
    localparam int SB_INSTR_XL  = 11;
    localparam int SB_PRIV_LO   = 12;

    localparam logic [STAT_W-1:0] KEEP_MASK =
        (STAT_W'(1) << SB_USER_MON)  | (STAT_W'(1) << SB_FP_LO_MOD) |
        (STAT_W'(1) << SB_FP_HI_MOD) | (STAT_W'(1) << SB_KEY_EN)    |
        (STAT_W'(1) << SB_DATA_XL)   | (STAT_W'(1) << SB_STACK_XL)  |
        (STAT_W'(1) << SB_MCHK_MASK) | (STAT_W'(1) << SB_INSTR_XL);

    // syndrome field positions
    localparam int YB_SLOT   = 0;
    localparam int YB_NOCOLL = 2;
    localparam int YB_KIND   = 3;
    localparam int YB_CODE   = 8;

    typedef enum logic [1:0] {
        IK_FAULT  = 2'd0,
        IK_TRAP   = 2'd1,
        IK_BRTRAP = 2'd2,
        IK_RSVD   = 2'd3
    } intr_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_SETTLE  = 2'd1,
        SQ_RELEASE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    output logic accept_o,
    output logic busy_o,
    output logic go_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        accept_o = 1'b0;
        busy_o   = 1'b0;
        go_o     = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (take_i) begin
                    accept_o = 1'b1;
                    state_d  = SQ_SETTLE;
                end
            end
            SQ_SETTLE: begin
                busy_o  = 1'b1;
                state_d = SQ_RELEASE;
            end
            SQ_RELEASE: begin
                busy_o  = 1'b1;
                go_o    = 1'b1;
                state_d = SQ_IDLE;
            end
            default: begin
                state_d = SQ_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/intr_status_builder.sv
module intr_status_builder
    import intr_capture_pkg::*;
(
    input  logic [STAT_W-1:0] cur_status_i,
    input  logic              def_endian_i,
    input  logic              def_pmon_i,
    output logic [STAT_W-1:0] new_status_o,
    output logic              collect_o
);

    logic [STAT_W-1:0] copy_bits;

    always_comb begin
        copy_bits               = '0;
        copy_bits[SB_ENDIAN]    = def_endian_i;
        copy_bits[SB_PRIV_MON]  = def_pmon_i;
        new_status_o            = (cur_status_i & KEEP_MASK) | copy_bits;
        collect_o               = cur_status_i[SB_COLLECT];
    end

endmodule

// File: rtl/intr_syndrome_builder.sv
module intr_syndrome_builder
    import intr_capture_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [1:0]        kind_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        slot_i,
    input  logic              long_slot_i,
    input  logic              alt_isa_i,
    input  logic              collect_i,
    output logic [SYN_W-1:0]  syndrome_o
);

    intr_kind_e kind;
    logic       is_trap;
    logic [1:0] slot_code;
    logic       no_coll;

    always_comb begin
        kind = intr_kind_e'(kind_i);
        unique case (kind)
            IK_TRAP, IK_BRTRAP: is_trap = 1'b1;
            default:            is_trap = 1'b0;
        endcase

        if (alt_isa_i) begin
            slot_code = 2'd0;
        end else if (long_slot_i) begin
            slot_code = is_trap ? 2'd2 : 2'd1;
        end else begin
            slot_code = slot_i;
        end

        no_coll = !alt_isa_i && !collect_i;

        syndrome_o                          = '0;
        syndrome_o[YB_SLOT +: 2]            = slot_code;
        syndrome_o[YB_NOCOLL]               = no_coll;
        syndrome_o[YB_KIND +: 2]            = kind_i;
        syndrome_o[YB_CODE +: CODE_W]       = code_i;
    end

endmodule

// File: rtl/intr_vector_table.sv
module intr_vector_table #(
    parameter int ADDR_W     = 64,
    parameter int CODE_W     = 4,
    parameter int STRIDE     = 1024,
    parameter int BASE_ZEROS = 15
) (
    input  logic [ADDR_W-1:0] vec_base_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [ADDR_W-1:0] vec_addr_o
);

    localparam int VEC_COUNT = 1 << CODE_W;
    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << BASE_ZEROS) - ADDR_W'(1));

    logic [ADDR_W-1:0] ofs_tab [VEC_COUNT];

    for (genvar g = 0; g < VEC_COUNT; g++) begin : g_ofs
        assign ofs_tab[g] = ADDR_W'(g * STRIDE);
    end

    assign vec_addr_o = (vec_base_i & BASE_MASK) + ofs_tab[code_i];

endmodule

// File: rtl/intr_capture_unit.sv
module intr_capture_unit
    import intr_capture_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int CODE_W     = 4,
    parameter int STRIDE     = 1024,
    parameter int BASE_ZEROS = 15,
    parameter int FS_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [1:0]        kind_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        slot_i,
    input  logic              long_slot_i,
    input  logic              alt_isa_i,
    input  logic              nested_dtlb_i,
    input  logic [STAT_W-1:0] cur_status_i,
    input  logic              def_endian_i,
    input  logic              def_pmon_i,
    input  logic [ADDR_W-1:0] vec_base_i,
    input  logic [ADDR_W-1:0] cur_ip_i,
    input  logic [ADDR_W-1:0] next_ip_i,
    input  logic [ADDR_W-1:0] branch_tgt_i,
    input  logic [ADDR_W-1:0] last_ok_ip_i,
    input  logic [ADDR_W-1:0] fault_addr_i,
    output logic              busy_o,
    output logic              fetch_go_o,
    output logic [ADDR_W-1:0] fetch_ip_o,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] saved_status_o,
    output logic [ADDR_W-1:0] saved_ip_o,
    output logic [ADDR_W-1:0] last_ip_o,
    output logic [ADDR_W-1:0] param_addr_o,
    output logic [FS_W-1:0]   fstate_o,
    output logic [SYN_W-1:0]  syndrome_o,
    output logic              cfle_o
);

    localparam logic [FS_W-1:0] FS_VALID_ONLY = FS_W'(1);

    logic              accept;
    logic              collect;
    logic [STAT_W-1:0] new_status;
    logic [SYN_W-1:0]  new_syndrome;
    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] resume_ip;
    logic [ADDR_W-1:0] last_pick;

    intr_seq_fsm u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .go_o     (fetch_go_o)
    );

    intr_status_builder u_stat (
        .cur_status_i (cur_status_i),
        .def_endian_i (def_endian_i),
        .def_pmon_i   (def_pmon_i),
        .new_status_o (new_status),
        .collect_o    (collect)
    );

    intr_syndrome_builder #(.CODE_W(CODE_W)) u_syn (
        .kind_i      (kind_i),
        .code_i      (code_i),
        .slot_i      (slot_i),
        .long_slot_i (long_slot_i),
        .alt_isa_i   (alt_isa_i),
        .collect_i   (collect),
        .syndrome_o  (new_syndrome)
    );

    intr_vector_table #(
        .ADDR_W     (ADDR_W),
        .CODE_W     (CODE_W),
        .STRIDE     (STRIDE),
        .BASE_ZEROS (BASE_ZEROS)
    ) u_vec (
        .vec_base_i (vec_base_i),
        .code_i     (code_i),
        .vec_addr_o (vec_addr)
    );

    // resume address and last-IP source selection
    always_comb begin
        unique case (intr_kind_e'(kind_i))
            IK_TRAP:   resume_ip = next_ip_i;
            IK_BRTRAP: resume_ip = branch_tgt_i;
            default:   resume_ip = cur_ip_i;
        endcase
        last_pick = alt_isa_i ? cur_ip_i : last_ok_ip_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_ip_o     <= '0;
            status_o       <= '0;
            saved_status_o <= '0;
            saved_ip_o     <= '0;
            last_ip_o      <= '0;
            param_addr_o   <= '0;
            fstate_o       <= FS_VALID_ONLY;
            syndrome_o     <= '0;
            cfle_o         <= 1'b1;
        end else if (accept) begin
            fetch_ip_o <= vec_addr;
            status_o   <= new_status;
            fstate_o   <= '0;
            cfle_o     <= 1'b0;
            if (!nested_dtlb_i) begin
                syndrome_o <= new_syndrome;
            end
            if (collect) begin
                saved_status_o <= cur_status_i;
                saved_ip_o     <= resume_ip;
                last_ip_o      <= last_pick;
                param_addr_o   <= fault_addr_i;
            end
        end
    end

endmodule

// File: rtl/intr_capture_unit_chk.sv
module intr_capture_unit_chk #(
    parameter int ADDR_W     = 64,
    parameter int FS_W       = 8,
    parameter int ALIGN_BITS = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alt_isa_i,
    input logic              nested_dtlb_i,
    input logic              collect_en_i,
    input logic              busy_o,
    input logic              fetch_go_o,
    input logic [ADDR_W-1:0] fetch_ip_o,
    input logic [ADDR_W-1:0] saved_ip_o,
    input logic [ADDR_W-1:0] last_ip_o,
    input logic [31:0]       status_o,
    input logic [FS_W-1:0]   fstate_o,
    input logic [15:0]       syndrome_o,
    input logic              cfle_o
);

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(saved_ip_o) && $stable(fetch_ip_o)); // R12

    AST_GO_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |-> $past(busy_o) && !$past(fetch_go_o)); // R11

    AST_GO_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |=> !busy_o); // R11

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |-> fetch_ip_o[ALIGN_BITS-1:0] == '0); // R11

    AST_PRIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> status_o[13:12] == 2'b00); // R9

    AST_FSTATE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> fstate_o == '0); // R5

    AST_CFLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !cfle_o); // R10

    AST_NOCOLL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) && !$past(collect_en_i) |-> $stable(saved_ip_o) && $stable(last_ip_o)); // R4

    AST_NESTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) && $past(nested_dtlb_i) |-> $stable(syndrome_o)); // R6

    AST_ALT_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) && $past(alt_isa_i) && !$past(nested_dtlb_i) |-> syndrome_o[2:0] == 3'b000); // R7 R8

endmodule

bind intr_capture_unit intr_capture_unit_chk #(
    .ADDR_W (ADDR_W),
    .FS_W   (FS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alt_isa_i     (alt_isa_i),
    .nested_dtlb_i (nested_dtlb_i),
    .collect_en_i  (cur_status_i[3]),
    .busy_o        (busy_o),
    .fetch_go_o    (fetch_go_o),
    .fetch_ip_o    (fetch_ip_o),
    .saved_ip_o    (saved_ip_o),
    .last_ip_o     (last_ip_o),
    .status_o      (status_o),
    .fstate_o      (fstate_o),
    .syndrome_o    (syndrome_o),
    .cfle_o        (cfle_o)
);

// File: tb/intr_capture_unit_test.sv
`timescale 1ns/1ps
module intr_capture_unit_test;

    localparam logic [31:0] KEEP = 32'h0000_0F27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [3:0]  code = 4'd0;
    logic [1:0]  slot = 2'd0;
    logic        lslot = 1'b0;
    logic        alt = 1'b0;
    logic        nest = 1'b0;
    logic [31:0] cstat = 32'h0;
    logic        dend = 1'b0;
    logic        dpm = 1'b0;
    logic [63:0] vbase = 64'h0, cip = 64'h0, nip = 64'h0, btgt = 64'h0, lok = 64'h0, faddr = 64'h0;

    logic        busy, go, cfle;
    logic [63:0] fip, sip, lip, pad;
    logic [31:0] stat, sstat;
    logic [7:0]  fst;
    logic [15:0] syn;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model of the saved registers
    logic [63:0] m_sip = 64'h0, m_lip = 64'h0, m_pad = 64'h0, m_fip = 64'h0;
    logic [31:0] m_sstat = 32'h0, m_stat = 32'h0;
    logic [15:0] m_syn = 16'h0;

    intr_capture_unit uut (
        .clk(clk), .rst_n(rst_n), .take_i(take), .kind_i(kind), .code_i(code),
        .slot_i(slot), .long_slot_i(lslot), .alt_isa_i(alt), .nested_dtlb_i(nest),
        .cur_status_i(cstat), .def_endian_i(dend), .def_pmon_i(dpm), .vec_base_i(vbase),
        .cur_ip_i(cip), .next_ip_i(nip), .branch_tgt_i(btgt), .last_ok_ip_i(lok),
        .fault_addr_i(faddr), .busy_o(busy), .fetch_go_o(go), .fetch_ip_o(fip),
        .status_o(stat), .saved_status_o(sstat), .saved_ip_o(sip), .last_ip_o(lip),
        .param_addr_o(pad), .fstate_o(fst), .syndrome_o(syn), .cfle_o(cfle)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // update the model from the requirements, before a commit
    task automatic model_commit();
        logic [1:0] sl;
        bit coll;
        coll = cstat[3];
        if (alt) sl = 2'd0;
        else if (lslot) sl = (kind == 2'd1 || kind == 2'd2) ? 2'd2 : 2'd1;
        else sl = slot;
        if (!nest) m_syn = {4'h0, code, 3'b000, kind, (!alt && !coll), sl};
        m_stat = (cstat & KEEP) | (32'(dend) << 6) | (32'(dpm) << 7);
        m_fip = (vbase & ~64'h7FFF) + 64'(code) * 64'h400;
        if (coll) begin
            m_sstat = cstat;
            m_pad   = faddr;
            m_lip   = alt ? cip : lok;
            case (kind)
                2'd1:    m_sip = nip;
                2'd2:    m_sip = btgt;
                default: m_sip = cip;
            endcase
        end
    endtask

    task automatic do_take();
        model_commit();
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
        check("R11", "busy after commit", {63'h0, busy}, 64'd1);
        check("R11", "go in settle", {63'h0, go}, 64'd0);
        @(negedge clk);
        check("R11", "go in release", {63'h0, go}, 64'd1);
        check("R11", "fetch ip", fip, m_fip);
        @(negedge clk);
        check("R11", "busy end", {63'h0, busy}, 64'd0);
        check("R11", "go end", {63'h0, go}, 64'd0);
    endtask

    task automatic check_regs(input string tag);
        check("R2", {tag, " saved status"}, {32'h0, sstat}, {32'h0, m_sstat});
        check("R2", {tag, " saved ip"}, sip, m_sip);
        check("R2", {tag, " param"}, pad, m_pad);
        check("R3", {tag, " last ip"}, lip, m_lip);
        check("R5", {tag, " fstate"}, {56'h0, fst}, 64'h0);
        check("R6", {tag, " syndrome"}, {48'h0, syn}, {48'h0, m_syn});
        check("R9", {tag, " status"}, {32'h0, stat}, {32'h0, m_stat});
        check("R10", {tag, " cfle"}, {63'h0, cfle}, 64'h0);
    endtask

    task automatic t_reset();
        check("R1", "busy", {63'h0, busy}, 64'h0);
        check("R1", "go", {63'h0, go}, 64'h0);
        check("R1", "status", {32'h0, stat}, 64'h0);
        check("R1", "saved ip", sip, 64'h0);
        check("R1", "syndrome", {48'h0, syn}, 64'h0);
        check("R1", "fetch ip", fip, 64'h0);
        check("R1", "fstate", {56'h0, fst}, 64'h1);
        check("R1", "cfle", {63'h0, cfle}, 64'h1);
    endtask

    task automatic t_fault();
        kind = 2'd0; code = 4'd3; slot = 2'd1; lslot = 1'b0; alt = 1'b0; nest = 1'b0;
        cstat = 32'hFFFF_FFFF; dend = 1'b0; dpm = 1'b1;
        vbase = 64'hA000_0000_0001_0000;
        cip = 64'h1111_0000_0000_0010; nip = 64'h2222_0000_0000_0020;
        btgt = 64'h3333_0000_0000_0030; lok = 64'h4444_0000_0000_0000;
        faddr = 64'hDEAD_BEEF_0000_1234;
        do_take();
        check_regs("R2 fault");
        check("R7", "plain slot", {62'h0, syn[1:0]}, 64'd1);
        check("R9", "priv zero", {62'h0, stat[13:12]}, 64'd0);
    endtask

    task automatic t_trap_long();
        kind = 2'd1; code = 4'd5; slot = 2'd0; lslot = 1'b1;
        cstat = 32'h0000_5A5B; dend = 1'b1; dpm = 1'b0;
        cip = 64'h1000_0000_0000_0040; nip = 64'h1000_0000_0000_0050;
        do_take();
        check_regs("R2 trap");
        check("R7", "trap long slot", {62'h0, syn[1:0]}, 64'd2);
    endtask

    task automatic t_brtrap_long();
        kind = 2'd2; code = 4'd6; lslot = 1'b1;
        btgt = 64'h7777_0000_0000_8880;
        do_take();
        check_regs("R2 brtrap");
        check("R7", "brtrap long slot", {62'h0, syn[1:0]}, 64'd2);
    endtask

    task automatic t_fault_long();
        kind = 2'd0; code = 4'd1; lslot = 1'b1; slot = 2'd0;
        cip = 64'h0000_1234_5678_0000;
        do_take();
        check_regs("R7 fault long");
        check("R7", "fault long slot", {62'h0, syn[1:0]}, 64'd1);
    endtask

    task automatic t_alt();
        kind = 2'd1; code = 4'd2; lslot = 1'b1; slot = 2'd2; alt = 1'b1;
        cip = 64'h0000_00AB_CDEF_0000; lok = 64'h0000_0000_1111_2222;
        do_take();
        check_regs("R3 alt");
        check("R3", "alt last ip", lip, 64'h0000_00AB_CDEF_0000);
        check("R8", "alt slot and nocoll", {61'h0, syn[2:0]}, 64'd0);
        alt = 1'b0;
    endtask

    task automatic t_no_collect();
        logic [63:0] prev_sip;
        prev_sip = m_sip;
        kind = 2'd2; code = 4'd9; lslot = 1'b0; slot = 2'd2;
        cstat = 32'hFFFF_FFF7; dend = 1'b1; dpm = 1'b1;
        cip = 64'h9999_0000_0000_0000; btgt = 64'h8888_0000_0000_0000;
        lok = 64'h6666_0000_0000_0000; faddr = 64'h5555_0000_0000_0000;
        do_take();
        check_regs("R4 nocoll");
        check("R4", "saved ip kept", sip, prev_sip);
        check("R8", "nocoll bit", {63'h0, syn[2]}, 64'd1);
    endtask

    task automatic t_nested();
        logic [15:0] prev_syn;
        prev_syn = m_syn;
        kind = 2'd0; code = 4'd12; slot = 2'd1; nest = 1'b1;
        cstat = 32'h0000_0008; vbase = 64'h0000_0000_0022_0000;
        do_take();
        check_regs("R6 nested");
        check("R6", "syndrome kept", {48'h0, syn}, {48'h0, prev_syn});
        nest = 1'b0;
    endtask

    task automatic t_busy_ignore();
        logic [63:0] keep_sip, keep_fip;
        kind = 2'd1; code = 4'd4; cstat = 32'h0000_0008;
        nip = 64'h0ABC_0000_0000_0100; vbase = 64'h0000_0000_0004_0000;
        model_commit();
        keep_sip = m_sip; keep_fip = m_fip;
        take = 1'b1;
        @(negedge clk);
        // still asserted in settle with new inputs
        kind = 2'd2; code = 4'd15; btgt = 64'hFFFF_0000_0000_0000; vbase = 64'hF000_0000_0000_0000;
        @(negedge clk);
        check("R12", "saved ip in release", sip, keep_sip);
        check("R12", "fetch ip in release", fip, keep_fip);
        take = 1'b0;
        @(negedge clk);
        check("R12", "saved ip after", sip, keep_sip);
        check("R12", "fetch ip after", fip, keep_fip);
        check("R12", "idle after", {63'h0, busy}, 64'd0);
    endtask

    task automatic t_vec_mask();
        kind = 2'd0; code = 4'd15; cstat = 32'h0000_0008;
        vbase = 64'h0123_4567_89AB_FFFF;
        do_take();
        check("R11", "masked base top vector", fip, 64'h0123_4567_89AB_BC00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fault();
        t_trap_long();
        t_brtrap_long();
        t_fault_long();
        t_alt();
        t_no_collect();
        t_nested();
        t_busy_ignore();
        t_vec_mask();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #80000;
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule